// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block takes two packed binary floating-point words (sign, biased exponent, fraction) and returns their product in the same format. The result sign is the exclusive OR of the operand signs. The stored exponents are summed and one bias is removed. The two significands, each with its implicit leading one restored, are multiplied. The product is normalised by at most one position and packed again. Results are truncated, not rounded. Denormals and NaN are not supported.

An exponent field of all zeros always means zero, and an exponent field of all ones always means infinity, whatever the fraction holds. A computed exponent that is too large saturates to infinity. A computed exponent that is too small flushes to zero. The default configuration is 32-bit single precision (8 exponent bits, 23 fraction bits). The field widths are parameters, and a parameter chooses between a one-cycle significand multiplier and an iterative shift-add multiplier.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. Only one operation is in flight at a time. An operand pair is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low until the result has been taken. The result is held, unchanged, while `out_valid` is high and `out_ready` is low, and it is consumed on the edge where both are high.

Top module: `spfp_mul`

## Requirements
- R1: The result sign bit (MSB) equals the XOR of the two operand sign bits for every result, including zero and infinity results.
- R2: For two finite, nonzero operands whose significand product is below 2.0, the exponent field is exp_a + exp_b - BIAS and the fraction is the truncated product bits just below the leading one. BIAS is 2^(EXP_W-1)-1.
- R3: When the significand product is 2.0 or more, the product is shifted right by one, the exponent field is incremented, and the low bits are discarded without rounding.
- R4: If either operand has an exponent field of 0, the result is zero (exponent 0, fraction 0). This includes zero times infinity.
- R5: If either operand has an all-ones exponent field and neither operand is zero, the result is infinity (exponent all ones, fraction 0), whatever the operand fractions hold.
- R6: If the computed exponent is all ones or greater, the result is infinity (exponent all ones, fraction 0).
- R7: If the computed exponent is 0 or less, the result is flushed to zero (exponent 0, fraction 0).
- R8: `in_ready` is high only while no operation is in flight. After an accept, `in_ready` stays low until the result is consumed.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R10: After reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | 1+EXP_W+FRAC_W | First operand {sign, exponent, fraction} |
| in_b | input | 1+EXP_W+FRAC_W | Second operand {sign, exponent, fraction} |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 1+EXP_W+FRAC_W | Product {sign, exponent, fraction} |

## Verification
The multiplier is built with a 4-bit exponent and a 3-bit fraction. Every first operand is paired with a second-operand set that covers every sign and exponent combination, so each value class meets every other: zero, infinity, normal values that need no shift, normal values that need the one-step shift, and exponent sums that overflow or underflow. For each result, the bench checks the sign separately from the magnitude. This separates a sign error from an exponent or fraction error, and it separates the special-value rules from the saturation and flush rules. Some operations have the consumer stall for several cycles, which shows whether the held result stays stable and whether the input side stays closed while the result waits.

// File: rtl/spfp_mul_pkg.sv
package spfp_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_HOLD = 2'd2
  } spfp_state_e;
endpackage

// File: rtl/spfp_unpack.sv
module spfp_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int MW    = FRAC_W + 1
) (
  input  logic [W-1:0]     word,
  output logic             sign,
  output logic [EXP_W-1:0] expo,
  output logic [MW-1:0]    mant,
  output logic             is_zero,
  output logic             is_inf
);
  assign sign    = word[W-1];
  assign expo    = word[W-2 -: EXP_W];
  assign mant    = {1'b1, word[FRAC_W-1:0]};
  assign is_zero = (expo == '0);
  assign is_inf  = (expo == '1);
endmodule

// File: rtl/spfp_mant_mul.sv
module spfp_mant_mul #(
  parameter int MW        = 24,
  parameter bit ITERATIVE = 1'b1,
  localparam int PW       = 2 * MW,
  localparam int CW       = $clog2(MW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [MW-1:0] a,
  input  logic [MW-1:0] b,
  output logic          done,
  output logic [PW-1:0] prod
);
  generate
    if (ITERATIVE) begin : g_iter
      logic [PW-1:0] acc_q, mcand_q;
      logic [MW-1:0] mplier_q;
      logic [CW-1:0] cnt_q;
      logic          busy_q, done_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc_q    <= '0;
          mcand_q  <= '0;
          mplier_q <= '0;
          cnt_q    <= '0;
          busy_q   <= 1'b0;
          done_q   <= 1'b0;
        end else if (start) begin
          acc_q    <= '0;
          mcand_q  <= {{MW{1'b0}}, a};
          mplier_q <= b;
          cnt_q    <= CW'(MW);
          busy_q   <= 1'b1;
          done_q   <= 1'b0;
        end else if (busy_q) begin
          if (mplier_q[0]) acc_q <= acc_q + mcand_q;
          mcand_q  <= mcand_q << 1;
          mplier_q <= mplier_q >> 1;
          cnt_q    <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          done_q <= 1'b0;
        end
      end

      assign done = done_q;
      assign prod = acc_q;
    end else begin : g_par
      logic [PW-1:0] prod_q;
      logic          done_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prod_q <= '0;
          done_q <= 1'b0;
        end else begin
          done_q <= start;
          if (start) prod_q <= PW'(a) * PW'(b);
        end
      end

      assign done = done_q;
      assign prod = prod_q;
    end
  endgenerate
endmodule

// File: rtl/spfp_pack.sv
module spfp_pack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int MW    = FRAC_W + 1,
  localparam int PW    = 2 * MW,
  localparam int XW    = EXP_W + 2,
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1,
  localparam int EMAX  = (1 << EXP_W) - 1
) (
  input  logic             sign,
  input  logic [EXP_W-1:0] exp_a,
  input  logic [EXP_W-1:0] exp_b,
  input  logic             zero_any,
  input  logic             inf_any,
  input  logic [PW-1:0]    prod,
  output logic [W-1:0]     result
);
  localparam logic [XW-1:0] BIAS_V = XW'(BIAS);
  localparam logic [XW-1:0] EMAX_V = XW'(EMAX);

  logic              norm;
  logic [FRAC_W-1:0] frac;
  logic [XW-1:0]     e_sum;

  always_comb begin
    norm  = prod[PW-1];
    frac  = norm ? prod[PW-2 -: FRAC_W] : prod[PW-3 -: FRAC_W];
    e_sum = {2'b00, exp_a} + {2'b00, exp_b} + XW'(norm) - BIAS_V;

    if (zero_any)                                  result = {sign, {(W-1){1'b0}}};
    else if (inf_any)                              result = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if ($signed(e_sum) >= $signed(EMAX_V))    result = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if ($signed(e_sum) <= $signed(XW'(0)))    result = {sign, {(W-1){1'b0}}};
    else                                           result = {sign, e_sum[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/spfp_mul.sv
module spfp_mul
  import spfp_mul_pkg::*;
#(
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 23,
  parameter bit ITERATIVE = 1'b1,
  localparam int W        = 1 + EXP_W + FRAC_W,
  localparam int MW       = FRAC_W + 1,
  localparam int PW       = 2 * MW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  spfp_state_e state_q;

  logic             sa, sb, za, zb, ia, ib;
  logic [EXP_W-1:0] ea, eb;
  logic [MW-1:0]    ma, mb;

  spfp_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
    .word(in_a), .sign(sa), .expo(ea), .mant(ma), .is_zero(za), .is_inf(ia)
  );
  spfp_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
    .word(in_b), .sign(sb), .expo(eb), .mant(mb), .is_zero(zb), .is_inf(ib)
  );

  logic accept;
  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign accept    = in_valid && in_ready;

  logic             sign_q, zero_q, inf_q;
  logic [EXP_W-1:0] ea_q, eb_q;
  logic             mul_done;
  logic [PW-1:0]    prod;
  logic [W-1:0]     packed_res, res_q;

  spfp_mant_mul #(.MW(MW), .ITERATIVE(ITERATIVE)) u_mant (
    .clk(clk), .rst_n(rst_n), .start(accept), .a(ma), .b(mb),
    .done(mul_done), .prod(prod)
  );

  spfp_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
    .sign(sign_q), .exp_a(ea_q), .exp_b(eb_q), .zero_any(zero_q),
    .inf_any(inf_q), .prod(prod), .result(packed_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sign_q  <= 1'b0;
      zero_q  <= 1'b0;
      inf_q   <= 1'b0;
      ea_q    <= '0;
      eb_q    <= '0;
      res_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          sign_q  <= sa ^ sb;
          zero_q  <= za | zb;
          inf_q   <= ia | ib;
          ea_q    <= ea;
          eb_q    <= eb;
          state_q <= ST_BUSY;
        end
        ST_BUSY: if (mul_done) begin
          res_q   <= packed_res;
          state_q <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_data = res_q;
endmodule

// File: rtl/spfp_mul_checker.sv
module spfp_mul_checker #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);
  assert_closed_while_holding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_closed_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_held_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_infinity_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data[W-2 -: EXP_W] == '1) |-> (out_data[FRAC_W-1:0] == '0));

  assert_zero_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data[W-2 -: EXP_W] == '0) |-> (out_data[FRAC_W-1:0] == '0));
endmodule

bind spfp_mul spfp_mul_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/spfp_mul_tb.sv
`timescale 1ns/1ps
module spfp_mul_tb;
  localparam int EW = 4;
  localparam int FW = 3;
  localparam int W  = 1 + EW + FW;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_data;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit ended    = 1'b0;

  always #2.5 clk = ~clk;

  spfp_mul #(.EXP_W(EW), .FRAC_W(FW), .ITERATIVE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic check(input string req, input int act, input int exp_v);
    n_checks++;
    if (act != exp_v) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // Expected magnitude (exponent and fraction) and the requirement it falls under.
  function automatic int model_mag(input int a, input int b, output string req);
    int ea, eb, p, e, fr;
    ea = (a >> 3) & 15;
    eb = (b >> 3) & 15;
    if (ea == 0 || eb == 0) begin req = "R4"; return 0; end
    if (ea == 15 || eb == 15) begin req = "R5"; return 15 * 8; end
    p = (8 + (a & 7)) * (8 + (b & 7));
    e = ea + eb - 7;
    if (p >= 128) begin e = e + 1; fr = (p / 16) % 8; req = "R3"; end
    else begin fr = (p / 8) % 8; req = "R2"; end
    if (e >= 15) begin req = "R6"; return 15 * 8; end
    if (e <= 0) begin req = "R7"; return 0; end
    return e * 8 + fr;
  endfunction

  task automatic run_op(input int a, input int b, input bit stall);
    string req;
    int exp_mag, held;
    @(negedge clk);
    in_a = W'(a);
    in_b = W'(b);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 in_ready after accept", int'(in_ready), 0);
    while (!out_valid) @(negedge clk);
    if (stall) begin
      held = int'(out_data);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check("R9 valid held", int'(out_valid), 1);
        check("R9 data stable", int'(out_data), held);
        check("R8 closed while holding", int'(in_ready), 0);
      end
    end
    exp_mag = model_mag(a, b, req);
    check({req, " magnitude"}, int'(out_data[W-2:0]), exp_mag);
    check("R1 sign", int'(out_data[W-1]), ((a >> 7) ^ (b >> 7)) & 1);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    while (!ended) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !ended) begin
        ended = 1'b1;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected<=190000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 in_ready", int'(in_ready), 1);
    check("R10 out_valid", int'(out_valid), 0);
    check("R10 out_data", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after release", int'(in_ready), 1);

    // directed corners: zero times infinity, infinity with fraction bits, overflow, underflow
    run_op(8'h00, 8'h78, 1'b1);   // R4
    run_op(8'h7F, 8'hBA, 1'b0);   // R5
    run_op(8'h77, 8'h77, 1'b0);   // R6
    run_op(8'h08, 8'h88, 1'b1);   // R7
    run_op(8'h3F, 8'h3F, 1'b0);   // R3

    for (int a = 0; a < 256; a++) begin
      for (int j = 0; j < 32; j++) begin
        run_op(a, j * 8 + (j % 8), ((a + j) % 16) == 0);
      end
    end

    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule